// File: doc/BRIEF.md
# Sampling Power-Mode Controller

This block decides whether the sampling system of a serial-attached sensor front end runs or sleeps. It comes out of reset in sleep. To wake it, a host sends a 32-byte burst over the serial link. The first 26 bytes only pad the receive buffer. The packet engine decodes and CRC-checks the last six bytes as one command. The controller counts the bytes of the burst itself, so it knows whether a decoded packet closes a full wake burst. It then decides whether that packet wakes the sampler.

When awake, the controller tells the packet engine how to answer each decoded command. A disable command with a good CRC does not stop sampling at once. The current data-ready period ends first, the reply goes out in the following period, and sampling stops at the end of that reply period.

For every packet it answers, the controller raises a one-cycle response strobe with two qualifiers. One marks a command that is not allowed in the current mode. The other asks for all-zero data bytes in the reply.

Top module: `pmc_ctrl`

## Requirements
- R1: After reset, sample_en, resp_valid, cmd_unexpected and reply_zero are all 0.
- R2: The byte counter adds one for each byte_done pulse and stops at 32. In sleep, a pkt_done that arrives before the counter holds 32 gets no response and leaves the mode unchanged. Once 32 or more bytes have been received, the packet is treated as a wake attempt.
- R3: If cs_n is sampled high on more than GAP_CLKS consecutive clocks (default 8), the byte counter clears. Exactly GAP_CLKS high clocks keep the count.
- R4: A wake attempt with pkt_cmd = 0x11 (enable) and pkt_crc_ok = 1 gives, on the cycle after pkt_done: sample_en = 1, resp_valid = 1, reply_zero = 1 and cmd_unexpected = 0.
- R5: A failed wake attempt gives resp_valid = 1 and reply_zero = 1, and sample_en stays 0. cmd_unexpected is 1 exactly when pkt_cmd is not 0x11; an enable command with a bad CRC gives cmd_unexpected = 0.
- R6: Every wake attempt clears the byte counter. A further packet that is not preceded by 32 new bytes is ignored.
- R7: While awake, every pkt_done is answered with resp_valid = 1 and cmd_unexpected = 0. reply_zero is 1 only for 0x11 with a good CRC. A repeated enable command leaves sample_en at 1, and so does any other command except a good disable.
- R8: After pkt_cmd = 0x12 (disable) with pkt_crc_ok = 1, sample_en stays 1 through the next period_end. It drops on the cycle after the second period_end. Packets in between are answered as in R7. A disable command with a bad CRC has no effect.
- R9: Returning to sleep clears the byte counter, so bytes received while awake do not count toward a wake.
- R10: resp_valid, cmd_unexpected and reply_zero are single-cycle pulses, valid on the cycle after pkt_done. cmd_unexpected and reply_zero are 0 whenever resp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, already synchronised, active low |
| byte_done | input | 1 | One-cycle pulse per received serial byte |
| pkt_done | input | 1 | One-cycle pulse when the packet engine has decoded a packet |
| pkt_cmd | input | 8 | Command byte of the decoded packet |
| pkt_crc_ok | input | 1 | CRC of the decoded packet matched |
| period_end | input | 1 | One-cycle pulse at the end of each data-ready period |
| sample_en | output | 1 | Enables the sampling period generator |
| resp_valid | output | 1 | The packet engine must answer the last packet |
| cmd_unexpected | output | 1 | The answered command was not allowed in sleep |
| reply_zero | output | 1 | The reply carries zero data bytes |

## Verification
The three response outputs are registered. They are due on the first cycle after the clock edge that samples pkt_done. sample_en rises on that same cycle after a good wake. It falls on the cycle after the edge that samples the second period_end following a good disable. The bench changes inputs on the falling edge, reads each result on the next falling edge, and reads once more one cycle later to confirm that the pulses have ended. The cs_n gap rule is tested at GAP_CLKS and at GAP_CLKS+1 high clocks. The byte count is swept from 0 to 40, and every command code is swept with both CRC outcomes in both modes.

// File: rtl/pmc_pkg.sv
// Shared types and command codes for the sampling power-mode controller.
// Assumes 8-bit command bytes as delivered by the packet engine.
package pmc_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CMD_ENABLE  = 8'h11;
    localparam logic [CMD_W-1:0] CMD_DISABLE = 8'h12;

    // Power modes; the two drain states cover the disable grace periods
    typedef enum logic [1:0] {
        PM_SLEEP     = 2'd0,
        PM_AWAKE     = 2'd1,
        PM_DRAIN_CUR = 2'd2,
        PM_DRAIN_RPL = 2'd3
    } pm_state_e;

    // Per-packet answer request handed to the packet engine
    typedef struct packed {
        logic valid;
        logic unexpected;
        logic zero_data;
    } pm_resp_t;

endpackage

// File: rtl/pmc_byte_counter.sv
// Counts serial bytes toward a wake burst.
// The count stops at WAKE_BYTES. It clears after cs_n has been high for more
// than GAP_CLKS consecutive clocks, or when the mode logic requests it.
// Assumes cs_n is already synchronised to clk.
module pmc_byte_counter #(
    parameter int WAKE_BYTES = 32,
    parameter int GAP_CLKS   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic byte_done,
    input  logic clr,
    output logic frame_full
);

    localparam int CNT_W = $clog2(WAKE_BYTES + 1);
    localparam int GAP_W = $clog2(GAP_CLKS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WAKE_BYTES);
    localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(GAP_CLKS);

    logic [GAP_W-1:0] gap_q;
    logic [CNT_W-1:0] cnt_q;
    logic             idle_clr;

    // Measure how long chip select has stayed high, stopping at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (!cs_n) begin
            gap_q <= '0;
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // A gap longer than one byte time ends the burst
    always_comb begin
        idle_clr = cs_n && (gap_q == GAP_MAX);
    end

    // Count bytes, stopping at the wake length; a clear takes priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (idle_clr || clr) begin
            cnt_q <= '0;
        end else if (byte_done && (cnt_q != CNT_FULL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Report that a complete wake burst has arrived
    always_comb begin
        frame_full = (cnt_q == CNT_FULL);
    end

endmodule

// File: rtl/pmc_mode_fsm.sv
// Power-mode state machine.
// Sleep -> awake on a good enable packet that closes a full byte burst.
// Awake -> two drain periods on a good disable packet -> sleep.
// Assumes pkt_done and period_end are single-cycle pulses.
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic [CMD_W-1:0] pkt_cmd,
    input  logic             pkt_crc_ok,
    input  logic             period_end,
    input  logic             frame_full,
    output pm_state_e        state,
    output logic             wake_try,
    output logic             cnt_clr
);

    pm_state_e state_q;
    pm_state_e state_d;
    logic      good_enable;
    logic      good_disable;

    // Decode packet kinds that change the mode
    always_comb begin
        good_enable  = pkt_crc_ok && (pkt_cmd == CMD_ENABLE);
        good_disable = pkt_crc_ok && (pkt_cmd == CMD_DISABLE);
        wake_try     = pkt_done && frame_full && (state_q == PM_SLEEP);
    end

    // Next-mode selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_SLEEP: begin
                if (wake_try && good_enable) state_d = PM_AWAKE;
            end
            PM_AWAKE: begin
                if (pkt_done && good_disable) state_d = PM_DRAIN_CUR;
            end
            PM_DRAIN_CUR: begin
                if (period_end) state_d = PM_DRAIN_RPL;
            end
            PM_DRAIN_RPL: begin
                if (period_end) state_d = PM_SLEEP;
            end
            default: state_d = PM_SLEEP;
        endcase
    end

    // Mode register, sleep after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PM_SLEEP;
        end else begin
            state_q <= state_d;
        end
    end

    // Restart byte counting after every wake attempt and on entering sleep
    always_comb begin
        cnt_clr = wake_try || ((state_q == PM_DRAIN_RPL) && period_end);
    end

    assign state = state_q;

endmodule

// File: rtl/pmc_resp_gen.sv
// Builds the registered per-packet answer request for the packet engine.
// In sleep only wake attempts are answered, always with zero data bytes.
// Awake packets are answered; zero data only for a good enable.
module pmc_resp_gen
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic [CMD_W-1:0] pkt_cmd,
    input  logic             pkt_crc_ok,
    input  pm_state_e        state,
    input  logic             wake_try,
    output pm_resp_t         resp
);

    pm_resp_t resp_d;
    pm_resp_t resp_q;

    // Choose the answer for the packet decoded this cycle
    always_comb begin
        resp_d = '0;
        if (pkt_done) begin
            if (state == PM_SLEEP) begin
                if (wake_try) begin
                    resp_d.valid      = 1'b1;
                    resp_d.unexpected = (pkt_cmd != CMD_ENABLE);
                    resp_d.zero_data  = 1'b1;
                end
            end else begin
                resp_d.valid     = 1'b1;
                resp_d.zero_data = pkt_crc_ok && (pkt_cmd == CMD_ENABLE);
            end
        end
    end

    // Hold the answer for exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign resp = resp_q;

endmodule

// File: rtl/pmc_ctrl.sv
// Top of the sampling power-mode controller.
// Joins the byte counter, the mode state machine and the answer generator.
// Assumes all inputs are synchronous to clk.
module pmc_ctrl
    import pmc_pkg::*;
#(
    parameter int WAKE_BYTES = 32,
    parameter int GAP_CLKS   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       byte_done,
    input  logic       pkt_done,
    input  logic [7:0] pkt_cmd,
    input  logic       pkt_crc_ok,
    input  logic       period_end,
    output logic       sample_en,
    output logic       resp_valid,
    output logic       cmd_unexpected,
    output logic       reply_zero
);

    logic      frame_full;
    logic      cnt_clr;
    logic      wake_try;
    pm_state_e state;
    pm_resp_t  resp;

    pmc_byte_counter #(
        .WAKE_BYTES (WAKE_BYTES),
        .GAP_CLKS   (GAP_CLKS)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .byte_done  (byte_done),
        .clr        (cnt_clr),
        .frame_full (frame_full)
    );

    pmc_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_done   (pkt_done),
        .pkt_cmd    (pkt_cmd),
        .pkt_crc_ok (pkt_crc_ok),
        .period_end (period_end),
        .frame_full (frame_full),
        .state      (state),
        .wake_try   (wake_try),
        .cnt_clr    (cnt_clr)
    );

    pmc_resp_gen u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_done   (pkt_done),
        .pkt_cmd    (pkt_cmd),
        .pkt_crc_ok (pkt_crc_ok),
        .state      (state),
        .wake_try   (wake_try),
        .resp       (resp)
    );

    // Drive the ports from the mode register and the answer register
    always_comb begin
        sample_en      = (state != PM_SLEEP);
        resp_valid     = resp.valid;
        cmd_unexpected = resp.unexpected;
        reply_zero     = resp.zero_data;
    end

endmodule

// File: rtl/pmc_ctrl_chk.sv
// Port-level properties of the power-mode controller, bound to pmc_ctrl.
module pmc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pkt_done,
    input logic [7:0] pkt_cmd,
    input logic       pkt_crc_ok,
    input logic       period_end,
    input logic       sample_en,
    input logic       resp_valid,
    input logic       cmd_unexpected,
    input logic       reply_zero
);

    // Waking needs a good enable packet on the previous cycle
    assert_wake_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_en) |-> $past(pkt_done && pkt_crc_ok && (pkt_cmd == 8'h11)));

    // A flagged command happens only on a failed wake, and sleep holds
    assert_fail_sleeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_unexpected |-> (resp_valid && reply_zero && !sample_en));

    // Packets answered while awake are never flagged
    assert_awake_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_unexpected |-> !$past(sample_en));

    // Sampling stops only at a period boundary
    assert_stop_on_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_en) |-> $past(period_end));

    // Each answer follows a decoded packet
    assert_resp_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(pkt_done));

    // Qualifiers are silent without a response strobe
    assert_qual_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (!cmd_unexpected && !reply_zero));

endmodule

bind pmc_ctrl pmc_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pkt_done       (pkt_done),
    .pkt_cmd        (pkt_cmd),
    .pkt_crc_ok     (pkt_crc_ok),
    .period_end     (period_end),
    .sample_en      (sample_en),
    .resp_valid     (resp_valid),
    .cmd_unexpected (cmd_unexpected),
    .reply_zero     (reply_zero)
);

// File: tb/tb_pmc_ctrl.sv
module tb_pmc_ctrl;

    localparam int GAP  = 8;
    localparam int WAKE = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       byte_done = 1'b0;
    logic       pkt_done = 1'b0;
    logic [7:0] pkt_cmd = 8'h00;
    logic       pkt_crc_ok = 1'b0;
    logic       period_end = 1'b0;
    logic       sample_en;
    logic       resp_valid;
    logic       cmd_unexpected;
    logic       reply_zero;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic s_rv, s_un, s_zr, s_se, s_rv2;

    always #4 clk = ~clk;

    pmc_ctrl #(.WAKE_BYTES(WAKE), .GAP_CLKS(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_done(byte_done),
        .pkt_done(pkt_done), .pkt_cmd(pkt_cmd), .pkt_crc_ok(pkt_crc_ok),
        .period_end(period_end), .sample_en(sample_en), .resp_valid(resp_valid),
        .cmd_unexpected(cmd_unexpected), .reply_zero(reply_zero)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cs_n = 1'b0; byte_done = 1'b1;
            @(negedge clk); byte_done = 1'b0;
        end
    endtask

    // cs_n high on exactly k sampled edges
    task automatic idle(input int k);
        @(negedge clk); cs_n = 1'b1;
        repeat (k) @(negedge clk);
        cs_n = 1'b0;
    endtask

    task automatic send_pkt(input logic [7:0] cmd, input logic crc);
        @(negedge clk); pkt_done = 1'b1; pkt_cmd = cmd; pkt_crc_ok = crc;
        @(negedge clk); pkt_done = 1'b0;
        s_rv = resp_valid; s_un = cmd_unexpected; s_zr = reply_zero; s_se = sample_en;
        @(negedge clk);
        s_rv2 = resp_valid;
    endtask

    task automatic period();
        @(negedge clk); period_end = 1'b1;
        @(negedge clk); period_end = 1'b0;
    endtask

    task automatic go_sleep();
        send_pkt(8'h12, 1'b1);
        period();
        period();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 sample_en", sample_en, 0);
        chk("R1 resp_valid", resp_valid, 0);
        chk("R1 cmd_unexpected", cmd_unexpected, 0);
        chk("R1 reply_zero", reply_zero, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sample_en after release", sample_en, 0);

        // R2: byte count sweep ahead of an enable packet
        for (int n = 0; n <= 40; n++) begin
            idle(GAP + 1);
            send_bytes(n);
            send_pkt(8'h11, 1'b1);
            chk($sformatf("R2 n=%0d resp_valid", n), s_rv, (n >= WAKE) ? 1 : 0);
            chk($sformatf("R2 n=%0d sample_en", n), s_se, (n >= WAKE) ? 1 : 0);
            if (n >= WAKE) go_sleep();
        end

        // R4/R5/R10: every command code as a wake attempt, both CRC outcomes
        for (int c = 0; c < 256; c++) begin
            for (int k = 0; k < 2; k++) begin
                bit good;
                good = (c == 'h11) && (k == 1);
                idle(GAP + 1);
                send_bytes(WAKE);
                send_pkt(8'(c), k[0]);
                chk($sformatf("R4/R5 cmd=%0h crc=%0d resp_valid", c, k), s_rv, 1);
                chk($sformatf("R5 cmd=%0h crc=%0d cmd_unexpected", c, k), s_un, (c != 'h11) ? 1 : 0);
                chk($sformatf("R4/R5 cmd=%0h crc=%0d reply_zero", c, k), s_zr, 1);
                chk($sformatf("R4/R5 cmd=%0h crc=%0d sample_en", c, k), s_se, good ? 1 : 0);
                chk($sformatf("R10 cmd=%0h crc=%0d pulse", c, k), s_rv2, 0);
                if (good) go_sleep();
            end
        end

        // R6: attempt consumes the burst
        idle(GAP + 1);
        send_bytes(WAKE);
        send_pkt(8'h11, 1'b0);
        chk("R6 failed wake answered", s_rv, 1);
        send_pkt(8'h11, 1'b1);
        chk("R6 repeat without bytes ignored", s_rv, 0);
        chk("R6 still asleep", s_se, 0);
        send_bytes(WAKE);
        send_pkt(8'h11, 1'b1);
        chk("R6 fresh burst wakes", s_se, 1);
        go_sleep();
        chk("R8 asleep again", sample_en, 0);

        // R3: gap boundary
        idle(GAP + 1);
        send_bytes(20);
        idle(GAP);
        send_bytes(12);
        send_pkt(8'h11, 1'b1);
        chk("R3 gap of GAP_CLKS keeps count", s_se, 1);
        go_sleep();
        idle(GAP + 1);
        send_bytes(20);
        idle(GAP + 1);
        send_bytes(12);
        send_pkt(8'h11, 1'b1);
        chk("R3 gap of GAP_CLKS+1 clears count", s_rv, 0);
        chk("R3 no wake after long gap", s_se, 0);

        // R7: awake sweep, skipping the good disable
        idle(GAP + 1);
        send_bytes(WAKE);
        send_pkt(8'h11, 1'b1);
        chk("R7 woke for sweep", s_se, 1);
        for (int c = 0; c < 256; c++) begin
            for (int k = 0; k < 2; k++) begin
                if (!((c == 'h12) && (k == 1))) begin
                    send_pkt(8'(c), k[0]);
                    chk($sformatf("R7 cmd=%0h crc=%0d resp_valid", c, k), s_rv, 1);
                    chk($sformatf("R7 cmd=%0h crc=%0d cmd_unexpected", c, k), s_un, 0);
                    chk($sformatf("R7 cmd=%0h crc=%0d reply_zero", c, k), s_zr,
                        ((c == 'h11) && (k == 1)) ? 1 : 0);
                    chk($sformatf("R7/R8 cmd=%0h crc=%0d stays awake", c, k), s_se, 1);
                end
            end
        end

        // R9: bytes while awake, then R8 drain timing
        send_bytes(WAKE);
        send_pkt(8'h12, 1'b1);
        chk("R8 disable answered", s_rv, 1);
        chk("R8 awake after disable", s_se, 1);
        period();
        chk("R8 awake after first period", sample_en, 1);
        send_pkt(8'h05, 1'b1);
        chk("R8 drain packet answered", s_rv, 1);
        chk("R8 drain packet not flagged", s_un, 0);
        period();
        chk("R8 asleep after second period", sample_en, 0);
        send_pkt(8'h11, 1'b1);
        chk("R9 awake bytes discarded", s_rv, 0);
        chk("R9 still asleep", s_se, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule